// File: doc/BRIEF.md
# Serial debug link command engine

This block sits between a host byte stream (the deserialised and serialised sides of an 8n1 serial link at 1 Mbaud, whose framing and baud timing are handled elsewhere) and the register port of a debug module. It turns short command frames from the host into single APB3 reads and writes on an 8-bit address, 32-bit data bus. Each command produces a short reply, sent back one byte at a time over a valid/ready transmit stream.

The link starts asleep and listens only for a four-byte wake string. Once awake it decodes one-byte opcodes. These cover an identity query, a register read, a register write, a no-operation and a sleep command. A host recovers lost framing by sending six no-operation bytes, which is the length of the longest frame. Bytes that arrive while a bus transfer or reply is still pending are dropped, so the host pads each command with no-operation bytes to keep its own queue ahead of the replies.

Top module: `dbg_link_engine`

## Requirements
- R1: After reset the engine is asleep, psel and penable are low and tx_valid is low.
- R2: While asleep, received bytes other than the wake string cause no bus transfer and no reply.
- R3: The consecutive bytes 0x53, 0x55, 0x50, 0x3F wake the engine. After waking, opcode 0x01 returns the 32-bit identity parameter as four bytes, least significant first.
- R4: A byte that breaks a partial wake match restarts matching, and that byte counts as a first wake byte if it is 0x53.
- R5: Byte 0xA5 received in the opcode position puts the engine back to sleep, so that a following identity query gets no reply.
- R6: Opcode 0x02 followed by an address byte performs an APB read: one setup cycle, then an access phase held with stable address and control until pready. The read data is returned as four bytes, least significant first.
- R7: Opcode 0x03 followed by an address byte and four data bytes (least significant first) performs an APB write and returns one status byte: 0x00 normally, 0x01 when pslverr was high at completion.
- R8: Opcode 0x00 and every opcode value outside 0x00, 0x01, 0x02, 0x03 and 0xA5 produce no reply and no transfer.
- R9: Bytes received during a bus transfer or while a reply is being sent are discarded.
- R10: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R11: Six 0x00 bytes bring a partly received frame back to the opcode position, so that a following identity query is answered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Byte received from the host |
| rx_valid | input | 1 | rx_data is valid for this cycle |
| tx_data | output | 8 | Reply byte to the host |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | The serialiser takes tx_data this cycle |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB write when high |
| paddr | output | 8 | APB address |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB transfer completion |
| pslverr | input | 1 | APB error response |

## Verification
Each internal fault shows up at the ports within a few cycles. A frame counter stuck mid-frame produces a missing or wrongly addressed bus transfer on the next command. A wrong byte ordering in the reply shifter corrupts the first reply byte. A wake matcher that does not restart properly leaves the link asleep, which is seen as silence on the transmit stream after the wake string. Sweeping every address through reads, and a spread of addresses through writes with address-dependent wait states and error responses, exposes faults in byte lanes and in the phase sequencing.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  typedef enum logic [2:0] {
    LS_SLEEP, LS_OPCODE, LS_ADDR, LS_WDATA, LS_SETUP, LS_ACCESS, LS_REPLY
  } link_state_t;

  localparam logic [7:0] CMD_NOP   = 8'h00;
  localparam logic [7:0] CMD_IDENT = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;
  localparam logic [7:0] CMD_WRITE = 8'h03;
  localparam logic [7:0] CMD_SLEEP = 8'hA5;
endpackage

// File: rtl/dbg_wake_match.sv
module dbg_wake_match #(
  parameter int N = 4,
  parameter logic [8*N-1:0] SEQ = 32'h3F50_5553
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       hit
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;
  logic          match;

  assign match = byte_in == SEQ[8*idx +: 8];
  assign hit   = en && byte_valid && match && (idx == IW'(N-1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx <= '0;
    end else if (byte_valid) begin
      if (match)
        idx <= (idx == IW'(N-1)) ? '0 : idx + 1'b1;
      else
        idx <= (byte_in == SEQ[7:0]) ? IW'(1) : '0;
    end
  end
endmodule

// File: rtl/dbg_resp_shift.sv
module dbg_resp_shift #(
  parameter int W  = 32,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic [CW-1:0] load_cnt,
  output logic [BW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          busy
);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  assign tx_valid = cnt != '0;
  assign busy     = tx_valid;
  assign tx_data  = sh[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_data;
      cnt <= load_cnt;
    end else if (tx_valid && tx_ready) begin
      sh  <= sh >> BW;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dbg_link_engine.sv
module dbg_link_engine
  import dbg_link_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] IDENT = 32'h1DB6_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [AW-1:0] paddr,
  output logic [DW-1:0] pwdata,
  input  logic [DW-1:0] prdata,
  input  logic          pready,
  input  logic          pslverr
);
  localparam int NB  = DW / 8;
  localparam int CW  = $clog2(NB + 1);
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1;

  link_state_t    state;
  logic [BIW-1:0] bidx;
  logic           wake_hit;
  logic           sh_busy;
  logic           ld;
  logic [DW-1:0]  ld_data;
  logic [CW-1:0]  ld_cnt;

  dbg_wake_match #(.N(4), .SEQ(32'h3F50_5553)) u_wake (
    .clk(clk), .rst(rst), .en(state == LS_SLEEP),
    .byte_valid(rx_valid), .byte_in(rx_data), .hit(wake_hit)
  );

  dbg_resp_shift #(.W(DW), .BW(8)) u_shift (
    .clk(clk), .rst(rst), .load(ld), .load_data(ld_data), .load_cnt(ld_cnt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(sh_busy)
  );

  always_comb begin
    ld      = 1'b0;
    ld_data = '0;
    ld_cnt  = '0;
    if (state == LS_OPCODE && rx_valid && rx_data == CMD_IDENT) begin
      ld      = 1'b1;
      ld_data = IDENT;
      ld_cnt  = CW'(NB);
    end else if (state == LS_ACCESS && pready) begin
      ld = 1'b1;
      if (pwrite) begin
        ld_data = {{(DW-1){1'b0}}, pslverr};
        ld_cnt  = CW'(1);
      end else begin
        ld_data = prdata;
        ld_cnt  = CW'(NB);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LS_SLEEP;
      bidx    <= '0;
      psel    <= 1'b0;
      penable <= 1'b0;
      pwrite  <= 1'b0;
      paddr   <= '0;
      pwdata  <= '0;
    end else begin
      case (state)
        LS_SLEEP: if (wake_hit) state <= LS_OPCODE;
        LS_OPCODE: if (rx_valid) begin
          case (rx_data)
            CMD_IDENT: state <= LS_REPLY;
            CMD_READ:  begin pwrite <= 1'b0; state <= LS_ADDR; end
            CMD_WRITE: begin pwrite <= 1'b1; state <= LS_ADDR; end
            CMD_SLEEP: state <= LS_SLEEP;
            default:   state <= LS_OPCODE;
          endcase
        end
        LS_ADDR: if (rx_valid) begin
          paddr <= AW'(rx_data);
          bidx  <= '0;
          if (pwrite) begin
            state <= LS_WDATA;
          end else begin
            psel  <= 1'b1;
            state <= LS_SETUP;
          end
        end
        LS_WDATA: if (rx_valid) begin
          pwdata[8*bidx +: 8] <= rx_data;
          bidx <= bidx + 1'b1;
          if (bidx == BIW'(NB-1)) begin
            psel  <= 1'b1;
            state <= LS_SETUP;
          end
        end
        LS_SETUP: begin
          penable <= 1'b1;
          state   <= LS_ACCESS;
        end
        LS_ACCESS: if (pready) begin
          psel    <= 1'b0;
          penable <= 1'b0;
          state   <= LS_REPLY;
        end
        LS_REPLY: if (!sh_busy) state <= LS_OPCODE;
        default: state <= LS_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/dbg_link_checker.sv
module dbg_link_checker #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic          pready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready
);
  assert_enable_in_select_R6: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);

  assert_setup_then_access_R6: assert property (@(posedge clk) disable iff (rst)
    psel && !penable |=> psel && penable);

  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
    psel && penable && !pready |=> psel && penable && $stable(paddr)
      && $stable(pwrite) && $stable(pwdata));

  assert_release_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    psel && penable && pready |=> !psel && !penable);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_no_reply_during_bus_R9: assert property (@(posedge clk) disable iff (rst)
    psel |-> !tx_valid);
endmodule

bind dbg_link_engine dbg_link_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/sim_dbg_link_engine.sv
module sim_dbg_link_engine;
  localparam logic [31:0] ID = 32'h1DB6_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b1;
  logic psel, penable, pwrite;
  logic [7:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata = '0;
  logic pready = 1'b0;
  logic pslverr = 1'b0;

  always #2 clk = ~clk;

  dbg_link_engine #(.IDENT(ID)) u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  int vecs = 0, bad = 0, cyc = 0;
  logic [7:0] rq [0:15];
  int rq_n = 0;
  int nxfer = 0;
  logic [7:0] w_addr;
  logic [31:0] w_data;
  int wcnt = 0;
  logic stall = 1'b0;

  function automatic logic [31:0] rd_val(logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  // transmit sink and APB slave model, both acting at the falling edge
  always @(negedge clk) begin
    cyc++;
    tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (tx_valid && tx_ready && rq_n < 16) begin
      rq[rq_n] = tx_data;
      rq_n++;
    end
    if (psel && penable) begin
      if (wcnt >= int'(paddr[1:0])) begin
        pready  = 1'b1;
        prdata  = rd_val(paddr);
        pslverr = paddr[7:6] == 2'b11;
        nxfer++;
        if (pwrite) begin w_addr = paddr; w_data = pwdata; end
      end else begin
        pready = 1'b0;
        wcnt++;
      end
    end else begin
      pready = 1'b0; pslverr = 1'b0; wcnt = 0;
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    bad++;
    $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr(); rq_n = 0; endtask

  task automatic wait_tx(int n);
    for (int i = 0; i < 200 && rq_n < n; i++) @(negedge clk);
    idle(8);
  endtask

  function automatic logic [31:0] rq_word();
    return {rq[3], rq[2], rq[1], rq[0]};
  endfunction

  task automatic wake();
    put(8'h53); put(8'h55); put(8'h50); put(8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    check("R1 psel", {30'b0, psel, penable}, 0);

    // R2: commands while asleep
    clr(); put(8'h01); put(8'h02); put(8'h10); wait_tx(4);
    check("R2 no reply", rq_n, 0);
    check("R2 no xfer", nxfer, 0);

    // R3: wake and identity
    wake(); clr(); put(8'h01); wait_tx(4);
    check("R3 id count", rq_n, 4);
    check("R3 id value", rq_word(), ID);

    // R5: sleep, then identity ignored
    put(8'hA5); clr(); put(8'h01); wait_tx(4);
    check("R5 asleep", rq_n, 0);

    // R4: broken match restarts, 0x53 rechecked
    put(8'h53); put(8'h55); put(8'h53); put(8'h55); put(8'h50); put(8'h3F);
    clr(); put(8'h01); wait_tx(4);
    check("R4 restart 53 55 53", rq_word(), ID);
    put(8'hA5);
    put(8'h53); put(8'h53); put(8'h55); put(8'h50); put(8'h3F);
    clr(); put(8'h01); wait_tx(4);
    check("R4 restart 53 53", rq_word(), ID);
    put(8'hA5);
    put(8'h53); put(8'h55); put(8'h3F); put(8'h50); put(8'h3F);
    clr(); put(8'h01); wait_tx(4);
    check("R4 broken stays asleep", rq_n, 0);
    wake();

    // R8: NOP and undefined opcodes
    clr(); nxfer = 0;
    put(8'h00); put(8'h04); put(8'h7E); put(8'hFF); wait_tx(4);
    check("R8 no reply", rq_n, 0);
    check("R8 no xfer", nxfer, 0);
    clr(); put(8'h01); wait_tx(4);
    check("R8 still framed", rq_word(), ID);

    // R6: read sweep over every address, with stalls on transmit
    stall = 1'b1;
    for (int a = 0; a < 256; a++) begin
      clr(); put(8'h02); put(8'(a)); wait_tx(4);
      check("R6 read count", rq_n, 4);
      check("R6 read data", rq_word(), rd_val(8'(a)));
    end

    // R7: write sweep
    for (int a = 0; a < 256; a += 7) begin
      logic [31:0] d;
      d = (32'(a) * 32'h0101_0101) ^ 32'h0F0F_1234;
      clr(); put(8'h03); put(8'(a));
      put(d[7:0]); put(d[15:8]); put(d[23:16]); put(d[31:24]);
      wait_tx(1);
      check("R7 status count", rq_n, 1);
      check("R7 status", {24'b0, rq[0]}, (a >= 192) ? 1 : 0);
      check("R7 addr", {24'b0, w_addr}, 32'(a));
      check("R7 data", w_data, d);
    end
    stall = 1'b0;

    // R9: bytes during a pending transfer are dropped
    clr(); put(8'h02); put(8'h03); put(8'h01); put(8'h01); wait_tx(8);
    check("R9 count", rq_n, 4);
    check("R9 data", rq_word(), rd_val(8'h03));
    clr(); put(8'h01); put(8'h01); wait_tx(8);
    check("R9 during reply", rq_n, 4);

    // R11: six NOPs recover framing after a partial write frame
    clr(); put(8'h03); put(8'h12); put(8'hAA);
    repeat (6) put(8'h00);
    wait_tx(1); clr();
    put(8'h01); wait_tx(4);
    check("R11 resync count", rq_n, 4);
    check("R11 resync id", rq_word(), ID);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule